// File: doc/BRIEF.md
# Fine-Bin Calibration Histogram with Bin-Time Table

This block calibrates a tapped-delay time-to-digital converter whose delay taps are not all the same length. During a calibration run it receives a stream of fine bin numbers from the thermometer decoder. The events that produce these bin numbers are spread evenly over one clock period. The block counts how many events fall into each bin. Because the events are spread uniformly, a bin's share of the total count is its share of the clock period.

When the run has collected its configured number of events, the block steps through the bins one per cycle. For each bin it turns the count into a width in picoseconds. It also adds the widths into a running sum, which gives the calibrated start time of each bin. The resulting table maps a bin number to its time offset and its width, and it can be read back through a port with one cycle of latency. A done flag marks the table as valid.

The run length is a power of two, 2^run_log2, so the division by the total becomes a right shift. The clock period is a fixed parameter in picoseconds.

Top module: `tdc_cal_table`

## Requirements
- R1: After reset, cal_done is low and every table entry reads back as width 0 and time 0.
- R2: A cycle with cal_start high does three things: it clears every bin counter, it drops cal_done, and it begins a run of 2^run_log2 events. The run_log2 value is taken in that same cycle. A value above MAX_LOG2 is treated as MAX_LOG2, and run_log2 = 0 means a run of one event.
- R3: While a run is collecting, each cycle with ev_valid high adds one to the counter of bin ev_bin. A counter that has reached 2^CNT_W-1 stays there.
- R4: Counting stops on the clock edge that accepts event number 2^run_log2. From that edge the table is written one bin per cycle, and cal_done rises exactly NBINS clock edges later.
- R5: The width of bin b is floor(count_b × PERIOD_PS / 2^run_log2). A result above 2^OUT_W-1 is clamped to that value.
- R6: The time of bin b is the sum of the widths of bins 0 to b-1, clamped to 2^OUT_W-1, so bin 0 always has time 0. A bin with a count of zero gets width 0 and leaves the cumulative curve flat across it.
- R7: rd_width and rd_time show the entry for the rd_addr value presented in the previous cycle. Back-to-back addresses return back-to-back entries.
- R8: Events are ignored outside the collecting phase: while idle, while the table is being written, and after done. Such events change no entry and do not affect cal_done.
- R9: A cal_start during a run restarts the run. Counts gathered before the restart do not appear in the table.
- R10: Once raised, cal_done stays high until the next cal_start. It is low on the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Clears the histogram and begins a calibration run |
| run_log2 | input | LOG_W | Base-2 logarithm of the run's event total; taken on cal_start |
| ev_valid | input | 1 | A decoded event is present on ev_bin |
| ev_bin | input | BIN_W | Fine bin number of the event |
| cal_done | output | 1 | The table is complete and valid |
| rd_addr | input | BIN_W | Bin number to read from the table |
| rd_width | output | OUT_W | Calibrated bin width in picoseconds |
| rd_time | output | OUT_W | Calibrated bin start time in picoseconds |

## Verification
The bench builds the block with these parameter values:

| Parameter | Value |
|---|---|
| NBINS | 16 |
| CNT_W | 6 |
| MAX_LOG2 | 12 |
| PERIOD_PS | 8600 |
| OUT_W | 16 |

With 6-bit counters, a 128-event run in which most events fall into one bin drives that counter to its ceiling of 63 within a few hundred cycles. The 12-bit run limit means a run_log2 of 15 exercises the clamp with a run of only 4096 events. The 16-entry table keeps the done latency of R4 short enough to count cycle by cycle, and lets every entry be read back after each run.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;

   typedef enum logic [1:0] {
      CAL_IDLE,
      CAL_COLLECT,
      CAL_BUILD,
      CAL_DONE
   } cal_state_e;

endpackage

// File: rtl/tdc_cal_seq.sv
module tdc_cal_seq
   import tdc_cal_pkg::*;
#(
   parameter int NBINS    = 64,
   parameter int MAX_LOG2 = 20,
   parameter int LOG_W    = $clog2(MAX_LOG2 + 1),
   parameter int BIN_W    = $clog2(NBINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LOG_W-1:0] run_log2,
   input  logic             ev_valid,
   output logic             hist_clr,
   output logic             hist_inc,
   output logic             building,
   output logic             done,
   output logic [BIN_W-1:0] idx,
   output logic [LOG_W-1:0] lg
);

   localparam int         EVC_W = MAX_LOG2 + 1;
   localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NBINS - 1);

   cal_state_e       state_q;
   logic [EVC_W-1:0] ev_cnt_q;
   logic [EVC_W-1:0] ev_nxt;
   logic [EVC_W-1:0] target;
   logic [LOG_W-1:0] lg_q;
   logic [LOG_W-1:0] lg_in;
   logic [BIN_W-1:0] idx_q;
   logic             done_q;

   assign lg_in  = (int'(run_log2) > MAX_LOG2) ? LOG_W'(MAX_LOG2) : run_log2;
   assign target = EVC_W'(1) << lg_q;
   assign ev_nxt = ev_cnt_q + EVC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CAL_IDLE;
         ev_cnt_q <= '0;
         lg_q     <= '0;
         idx_q    <= '0;
         done_q   <= 1'b0;
      end else if (start) begin
         state_q  <= CAL_COLLECT;
         ev_cnt_q <= '0;
         lg_q     <= lg_in;
         idx_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         unique case (state_q)
            CAL_COLLECT: begin
               if (ev_valid) begin
                  ev_cnt_q <= ev_nxt;
                  if (ev_nxt == target) begin
                     state_q <= CAL_BUILD;
                     idx_q   <= '0;
                  end
               end
            end
            CAL_BUILD: begin
               idx_q <= idx_q + BIN_W'(1);
               if (idx_q == LAST_BIN) begin
                  state_q <= CAL_DONE;
                  done_q  <= 1'b1;
               end
            end
            default: begin
            end
         endcase
      end
   end

   assign hist_clr = start;
   assign hist_inc = (state_q == CAL_COLLECT) && ev_valid && !start;
   assign building = (state_q == CAL_BUILD);
   assign done     = done_q;
   assign idx      = idx_q;
   assign lg       = lg_q;

endmodule

// File: rtl/tdc_cal_hist.sv
module tdc_cal_hist #(
   parameter int NBINS = 64,
   parameter int CNT_W = 16,
   parameter int BIN_W = $clog2(NBINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [BIN_W-1:0] inc_bin,
   input  logic [BIN_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt
);

   logic [CNT_W-1:0] cnt [NBINS];

   for (genvar b = 0; b < NBINS; b++) begin : g_bin
      logic [CNT_W-1:0] c_q;
      logic             hit;

      assign hit = inc && (inc_bin == BIN_W'(b)) && (c_q != {CNT_W{1'b1}});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   c_q <= '0;
         else if (clr) c_q <= '0;
         else if (hit) c_q <= c_q + CNT_W'(1);
      end

      assign cnt[b] = c_q;
   end

   assign rd_cnt = cnt[rd_idx];

endmodule

// File: rtl/tdc_cal_scale.sv
module tdc_cal_scale #(
   parameter int CNT_W     = 16,
   parameter int PERIOD_PS = 8600,
   parameter int OUT_W     = 16,
   parameter int LOG_W     = 5
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [LOG_W-1:0] lg,
   output logic [OUT_W-1:0] width
);

   localparam int PW  = $clog2(PERIOD_PS + 1);
   localparam int PRW = CNT_W + PW;
   localparam int EW  = (PRW > OUT_W + 1) ? PRW : OUT_W + 1;

   logic [EW-1:0] prod;
   logic [EW-1:0] shifted;

   assign prod    = EW'(cnt) * EW'(PERIOD_PS);
   assign shifted = prod >> lg;
   assign width   = (shifted > EW'({OUT_W{1'b1}})) ? {OUT_W{1'b1}} : shifted[OUT_W-1:0];

endmodule

// File: rtl/tdc_cal_store.sv
module tdc_cal_store #(
   parameter int NBINS = 64,
   parameter int OUT_W = 16,
   parameter int BIN_W = $clog2(NBINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_clr,
   input  logic             wr_en,
   input  logic [BIN_W-1:0] wr_idx,
   input  logic [OUT_W-1:0] wr_width,
   input  logic [BIN_W-1:0] rd_addr,
   output logic [OUT_W-1:0] rd_width,
   output logic [OUT_W-1:0] rd_time
);

   logic [OUT_W-1:0] acc_q;
   logic [OUT_W:0]   sum;
   logic [OUT_W-1:0] acc_nxt;
   logic [OUT_W-1:0] wv [NBINS];
   logic [OUT_W-1:0] tv [NBINS];

   assign sum     = {1'b0, acc_q} + {1'b0, wr_width};
   assign acc_nxt = sum[OUT_W] ? {OUT_W{1'b1}} : sum[OUT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (acc_clr) acc_q <= '0;
      else if (wr_en)   acc_q <= acc_nxt;
   end

   for (genvar e = 0; e < NBINS; e++) begin : g_ent
      logic [OUT_W-1:0] w_q;
      logic [OUT_W-1:0] t_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= '0;
            t_q <= '0;
         end else if (wr_en && (wr_idx == BIN_W'(e))) begin
            w_q <= wr_width;
            t_q <= acc_q;
         end
      end

      assign wv[e] = w_q;
      assign tv[e] = t_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_width <= '0;
         rd_time  <= '0;
      end else begin
         rd_width <= wv[rd_addr];
         rd_time  <= tv[rd_addr];
      end
   end

endmodule

// File: rtl/tdc_cal_table.sv
module tdc_cal_table #(
   parameter int NBINS     = 64,
   parameter int CNT_W     = 16,
   parameter int PERIOD_PS = 8600,
   parameter int OUT_W     = 16,
   parameter int MAX_LOG2  = 20,
   parameter int BIN_W     = $clog2(NBINS),
   parameter int LOG_W     = $clog2(MAX_LOG2 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cal_start,
   input  logic [LOG_W-1:0] run_log2,
   input  logic             ev_valid,
   input  logic [BIN_W-1:0] ev_bin,
   output logic             cal_done,
   input  logic [BIN_W-1:0] rd_addr,
   output logic [OUT_W-1:0] rd_width,
   output logic [OUT_W-1:0] rd_time
);

   if (NBINS < 2 || (NBINS & (NBINS - 1)) != 0) begin : g_bad_nbins
      $error("NBINS must be a power of two of at least 2");
   end
   if (PERIOD_PS < 1 || PERIOD_PS >= (1 << OUT_W)) begin : g_bad_period
      $error("PERIOD_PS must be positive and fit in OUT_W bits");
   end
   if (MAX_LOG2 < 0 || MAX_LOG2 > 30) begin : g_bad_log2
      $error("MAX_LOG2 must lie in 0..30");
   end
   if (CNT_W < 1 || OUT_W < 1) begin : g_bad_width
      $error("CNT_W and OUT_W must be positive");
   end

   logic             hist_clr;
   logic             hist_inc;
   logic             building;
   logic [BIN_W-1:0] idx;
   logic [LOG_W-1:0] lg;
   logic [CNT_W-1:0] bin_cnt;
   logic [OUT_W-1:0] bin_width;

   tdc_cal_seq #(
      .NBINS   (NBINS),
      .MAX_LOG2(MAX_LOG2),
      .LOG_W   (LOG_W),
      .BIN_W   (BIN_W)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cal_start),
      .run_log2(run_log2),
      .ev_valid(ev_valid),
      .hist_clr(hist_clr),
      .hist_inc(hist_inc),
      .building(building),
      .done    (cal_done),
      .idx     (idx),
      .lg      (lg)
   );

   tdc_cal_hist #(
      .NBINS(NBINS),
      .CNT_W(CNT_W),
      .BIN_W(BIN_W)
   ) i_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hist_clr),
      .inc    (hist_inc),
      .inc_bin(ev_bin),
      .rd_idx (idx),
      .rd_cnt (bin_cnt)
   );

   tdc_cal_scale #(
      .CNT_W    (CNT_W),
      .PERIOD_PS(PERIOD_PS),
      .OUT_W    (OUT_W),
      .LOG_W    (LOG_W)
   ) i_scale (
      .cnt  (bin_cnt),
      .lg   (lg),
      .width(bin_width)
   );

   tdc_cal_store #(
      .NBINS(NBINS),
      .OUT_W(OUT_W),
      .BIN_W(BIN_W)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_clr (hist_clr),
      .wr_en   (building),
      .wr_idx  (idx),
      .wr_width(bin_width),
      .rd_addr (rd_addr),
      .rd_width(rd_width),
      .rd_time (rd_time)
   );

endmodule

// File: rtl/tdc_cal_table_chk.sv
module tdc_cal_table_chk #(
   parameter int BIN_W = 6,
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cal_start,
   input logic             ev_valid,
   input logic             cal_done,
   input logic             building,
   input logic [BIN_W-1:0] rd_addr,
   input logic [OUT_W-1:0] rd_width,
   input logic [OUT_W-1:0] rd_time
);

   p_done_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_done);

   p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !cal_start) |=> cal_done);

   p_done_after_build_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_done) |-> $past(building));

   p_build_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      building |-> !cal_done);

   p_table_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && $past(cal_done) && !cal_start && $stable(rd_addr))
      |=> ($stable(rd_width) && $stable(rd_time)));

   p_late_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && ev_valid && !cal_start) |=> (cal_done && !building));

endmodule

bind tdc_cal_table tdc_cal_table_chk #(
   .BIN_W(BIN_W),
   .OUT_W(OUT_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cal_start(cal_start),
   .ev_valid (ev_valid),
   .cal_done (cal_done),
   .building (building),
   .rd_addr  (rd_addr),
   .rd_width (rd_width),
   .rd_time  (rd_time)
);

// File: tb/test_tdc_cal_table.sv
`timescale 1ns/1ps
module test_tdc_cal_table;

   localparam int NB  = 16;
   localparam int CW  = 6;
   localparam int PER = 8600;
   localparam int OW  = 16;
   localparam int ML  = 12;
   localparam int BW  = 4;
   localparam int LW  = 4;
   localparam int CMAX = (1 << CW) - 1;
   localparam int OMAX = (1 << OW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cal_start = 1'b0;
   logic [LW-1:0] run_log2 = '0;
   logic          ev_valid = 1'b0;
   logic [BW-1:0] ev_bin = '0;
   logic          cal_done;
   logic [BW-1:0] rd_addr = '0;
   logic [OW-1:0] rd_width;
   logic [OW-1:0] rd_time;

   always #2.5 clk = ~clk;

   tdc_cal_table #(
      .NBINS(NB), .CNT_W(CW), .PERIOD_PS(PER), .OUT_W(OW), .MAX_LOG2(ML)
   ) i_tdc_cal_table (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .run_log2(run_log2),
      .ev_valid(ev_valid), .ev_bin(ev_bin), .cal_done(cal_done),
      .rd_addr(rd_addr), .rd_width(rd_width), .rd_time(rd_time)
   );

   typedef struct {
      int    addr;
      int    w;
      int    t;
      int    due;
      string req;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   int   cyc    = 0;

   // model state derived from the requirements
   int m_cnt [NB];
   int m_lg      = 0;
   int m_ev      = 0;
   bit m_collect = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pops expected entries when the read data is due
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         while (q.size() > 0 && q[0].due == cyc) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (int'(rd_width) != it.w || int'(rd_time) != it.t) begin
               fails++;
               $display("FAIL %s bin %0d: actual width %0d time %0d expected width %0d time %0d",
                        it.req, it.addr, rd_width, rd_time, it.w, it.t);
            end
         end
      end
   end

   // driver: present every address and push its expected entry
   task automatic read_all(input string req);
      int ew [NB];
      int et [NB];
      int acc = 0;
      for (int b = 0; b < NB; b++) begin
         int w;
         w = (m_cnt[b] * PER) >> m_lg;
         if (w > OMAX) w = OMAX;
         ew[b] = w;
         et[b] = acc;
         acc = acc + w;
         if (acc > OMAX) acc = OMAX;
      end
      for (int b = 0; b < NB; b++) begin
         exp_t it;
         @(negedge clk);
         rd_addr = BW'(b);
         it.addr = b; it.w = ew[b]; it.t = et[b]; it.due = cyc + 1; it.req = req;
         q.push_back(it);
      end
      while (q.size() > 0) @(posedge clk);
      #2;
   endtask

   task automatic do_start(input int lg);
      @(negedge clk);
      cal_start = 1'b1;
      run_log2  = LW'(lg);
      @(posedge clk);
      #1;
      cal_start = 1'b0;
      for (int b = 0; b < NB; b++) m_cnt[b] = 0;
      m_lg      = (lg > ML) ? ML : lg;
      m_ev      = 0;
      m_collect = 1'b1;
   endtask

   task automatic send_ev(input int b);
      @(negedge clk);
      ev_valid = 1'b1;
      ev_bin   = BW'(b);
      @(posedge clk);
      #1;
      ev_valid = 1'b0;
      if (m_collect) begin
         if (m_cnt[b] < CMAX) m_cnt[b]++;
         m_ev++;
         if (m_ev == (1 << m_lg)) m_collect = 1'b0;
      end
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!cal_done && n < 10000) begin
         @(posedge clk);
         #1;
         n++;
      end
   endtask

   initial begin
      int n;
      for (int b = 0; b < NB; b++) m_cnt[b] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk(cal_done == 1'b0, "R1", "done after reset", int'(cal_done), 0);
      read_all("R1");

      // R3 R5 R6 R7: uneven spread, one empty bin, one sparse bin
      do_start(8);
      for (int i = 0; i < 256; i++) begin
         int b;
         b = i % NB;
         if (b == 5) b = 6;
         if (b == 11 && (i % 3) != 0) b = 12;
         send_ev(b);
      end
      // R8: events while the table is being written are dropped
      send_ev(0); send_ev(0); send_ev(1);
      wait_done(n);
      chk(cal_done == 1'b1, "R4", "done after run", int'(cal_done), 1);
      read_all("R5 R6 R7");

      // R8 R10: events after done change nothing, done holds
      for (int i = 0; i < 5; i++) send_ev(i);
      chk(cal_done == 1'b1, "R10", "done held", int'(cal_done), 1);
      read_all("R8");

      // R3 R4: saturation and exact done latency
      do_start(7);
      chk(cal_done == 1'b0, "R10", "done dropped by start", int'(cal_done), 0);
      for (int i = 0; i < 100; i++) send_ev(3);
      for (int i = 0; i < 28; i++) send_ev(10);
      wait_done(n);
      chk(n == NB, "R4", "edges from final event to done", n, NB);
      read_all("R3");

      // R9: restart during a run discards earlier counts
      do_start(6);
      for (int i = 0; i < 20; i++) send_ev(2);
      do_start(4);
      for (int i = 0; i < 16; i++) send_ev(9);
      wait_done(n);
      chk(cal_done == 1'b1, "R9", "done after restarted run", int'(cal_done), 1);
      read_all("R9");

      // R2: one-event run
      do_start(0);
      send_ev(0);
      wait_done(n);
      chk(n == NB, "R2", "one-event run latency", n, NB);
      read_all("R2");

      // R2: run_log2 above the limit is clamped
      do_start(15);
      for (int i = 0; i < (1 << ML); i++) send_ev(i % NB);
      wait_done(n);
      chk(cal_done == 1'b1, "R2", "done after clamped run", int'(cal_done), 1);
      read_all("R2 clamp");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule